// File: doc/BRIEF.md
# Programmable bus wait-state controller

This block decides how many bus clocks each access on a small microcontroller bus lasts, and counts them out. The requester presents an access together with a code for the region it targets (register space, display RAM, on-chip memory, or one of four external chip-select regions) and a flag saying whether the external bus runs address and data multiplexed. The block latches the cycle length, holds a busy indication, and raises a one-clock completion pulse in the last bus clock of the cycle.

Three small control registers set the lengths. A mode register carries a global slow-down bit. A chip-select register carries a fast-access bit and a ready-enable bit for each external region. A guard register must be opened before the mode register accepts a write. Waited external cycles whose region has ready enabled can be stretched by an external ready line. Selecting multiplexed mode on a region marked fast sets a sticky error flag. The cycle still runs at the multiplexed length.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset all three control registers read 0, `acc_busy`, `acc_done` and `cfg_err` are 0, and `reg_rdata` is 0 at every address.
- R2: Register map (8-bit data): the mode register is at address 0x05 with the global wait bit at bit 7. The chip-select register is at 0x08; bits 7:4 are the fast bits for regions 0..3 (bit 4 = region 0) and bits 3:0 are the ready-enable bits for regions 0..3 (bit 0 = region 0). The guard register is at 0x0A with its open bit at bit 1. Unused bits and unmapped addresses read 0, and reads are combinational from `reg_addr`.
- R3: A write to the mode register changes it only while the guard bit is 1. Otherwise the write leaves the mode register unchanged.
- R4: `acc_area` codes 0 (register space) and 1 (display RAM) always give a 2-clock cycle, whatever the register settings and the multiplexed flag.
- R5: `acc_area` codes 2 and 3 (on-chip memory) give 1 clock when the global wait bit is 0 and 2 clocks when it is 1.
- R6: `acc_area` codes 4+i (external region i) with `acc_mux`=0 give 2 clocks when the global wait bit is 1. Otherwise they give 1 clock if fast bit i is 1 and 2 clocks if it is 0.
- R7: An external access with `acc_mux`=1 gives 3 clocks regardless of the global wait bit and the fast bit.
- R8: Accepting an external access with `acc_mux`=1 while that region's fast bit is 1 sets `cfg_err`, which then stays 1 until reset.
- R9: For an external access of 2 or more clocks whose region has ready enabled, each low sample of `bus_rdy` at the end of the last clock adds one clock to the cycle.
- R10: `bus_rdy` has no effect on 1-clock cycles, on non-external areas, or on regions whose ready-enable bit is 0.
- R11: A request is sampled at a rising edge when the block is idle or `acc_done` is 1. A cycle of N clocks then shows `acc_done` high only in the Nth clock period after that edge. Requests at other times are ignored, and the cycle length is fixed at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| acc_req | input | 1 | Access request |
| acc_area | input | 3 | Target region code |
| acc_mux | input | 1 | External bus runs multiplexed |
| bus_rdy | input | 1 | External ready, active high |
| acc_busy | output | 1 | A bus cycle is in progress |
| acc_done | output | 1 | Last clock of the current cycle |
| cfg_err | output | 1 | Sticky multiplexed/fast conflict flag |

## Verification
The bench sweeps every region code against both bus modes, both global wait settings and all sixteen fast-bit patterns, and measures each cycle length in clocks against an arithmetic model. A design with the priority order wrong would let the global bit or a fast bit shorten register-space or multiplexed cycles. A ready sample is driven low at the end of every cycle, so a design that stretches 1-clock cycles, or stretches regions whose ready is disabled, shows a length off by one. The guard test shows whether a mode write without the guard open leaks through. The conflict test shows whether the error flag fails to set or clears again. Requests raised in mid-cycle and held back-to-back show whether a request is accepted early or a pulse is lost between consecutive cycles.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
    localparam int unsigned CS_N   = 4;
    localparam int unsigned LEN_W  = 2;
    localparam int unsigned AREA_W = 3;

    typedef struct packed {
        logic            gw;
        logic [CS_N-1:0] cs_fast;
        logic [CS_N-1:0] rdy_en;
        logic            guard;
    } regs_t;

    typedef struct packed {
        logic             busy;
        logic [LEN_W-1:0] cnt;
        logic             use_rdy;
        logic             err;
    } timer_t;
endpackage

// File: rtl/bwc_regs.sv
module bwc_regs
    import bwc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned MODE_ADDR = 5,
    parameter int unsigned CSC_ADDR  = 8,
    parameter int unsigned GRD_ADDR  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              gw,
    output logic [CS_N-1:0]   cs_fast,
    output logic [CS_N-1:0]   rdy_en
);
    localparam int unsigned GW_BIT  = DATA_W - 1;
    localparam int unsigned GRD_BIT = 1;
    localparam int unsigned FAST_LO = DATA_W - CS_N;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            if (addr == ADDR_W'(MODE_ADDR)) begin
                if (r_q.guard) r_d.gw = wdata[GW_BIT];
            end else if (addr == ADDR_W'(CSC_ADDR)) begin
                r_d.cs_fast = wdata[FAST_LO +: CS_N];
                r_d.rdy_en  = wdata[0 +: CS_N];
            end else if (addr == ADDR_W'(GRD_ADDR)) begin
                r_d.guard = wdata[GRD_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(MODE_ADDR)) begin
            rdata[GW_BIT] = r_q.gw;
        end else if (addr == ADDR_W'(CSC_ADDR)) begin
            rdata[FAST_LO +: CS_N] = r_q.cs_fast;
            rdata[0 +: CS_N]       = r_q.rdy_en;
        end else if (addr == ADDR_W'(GRD_ADDR)) begin
            rdata[GRD_BIT] = r_q.guard;
        end
    end

    assign gw      = r_q.gw;
    assign cs_fast = r_q.cs_fast;
    assign rdy_en  = r_q.rdy_en;

    // R3
    guard_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(MODE_ADDR) && !r_q.guard) |=> $stable(r_q.gw));
endmodule

// File: rtl/bwc_len.sv
module bwc_len
    import bwc_pkg::*;
(
    input  logic [AREA_W-1:0] area,
    input  logic              mux,
    input  logic              gw,
    input  logic [CS_N-1:0]   cs_fast,
    input  logic [CS_N-1:0]   rdy_en,
    output logic [LEN_W-1:0]  len,
    output logic              rdy_use,
    output logic              cfg_bad
);
    localparam int unsigned IDX_W = $clog2(CS_N);

    logic             is_ext;
    logic             is_fixed;
    logic [IDX_W-1:0] idx;

    assign is_ext   = area[AREA_W-1];
    assign is_fixed = (area[AREA_W-1:1] == '0);
    assign idx      = area[IDX_W-1:0];

    always_comb begin
        if (is_fixed)               len = LEN_W'(2);
        else if (is_ext && mux)     len = LEN_W'(3);
        else if (gw)                len = LEN_W'(2);
        else if (!is_ext)           len = LEN_W'(1);
        else if (cs_fast[idx])      len = LEN_W'(1);
        else                        len = LEN_W'(2);
    end

    assign rdy_use = is_ext && rdy_en[idx] && (len != LEN_W'(1));
    assign cfg_bad = is_ext && mux && cs_fast[idx];
endmodule

// File: rtl/bwc_timer.sv
module bwc_timer
    import bwc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [LEN_W-1:0] len,
    input  logic             rdy_use,
    input  logic             cfg_bad,
    input  logic             rdy,
    output logic             busy,
    output logic             done,
    output logic             err
);
    timer_t t_d, t_q;
    logic   last, stall, accept;

    assign last   = t_q.busy && (t_q.cnt == LEN_W'(1));
    assign stall  = last && t_q.use_rdy && !rdy;
    assign done   = last && !stall;
    assign accept = req && (!t_q.busy || done);

    always_comb begin
        t_d = t_q;
        if (done) t_d.busy = 1'b0;
        if (accept) begin
            t_d.busy    = 1'b1;
            t_d.cnt     = len;
            t_d.use_rdy = rdy_use;
            if (cfg_bad) t_d.err = 1'b1;
        end else if (t_q.busy && !last) begin
            t_d.cnt = t_q.cnt - LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy = t_q.busy;
    assign err  = t_q.err;

    // R11
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !req) |=> !done);
    // R11
    single_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && len == LEN_W'(1)) |=> done);
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (busy && t_q.cnt == LEN_W'(1)));
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
    import bwc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned MODE_ADDR = 5,
    parameter int unsigned CSC_ADDR  = 8,
    parameter int unsigned GRD_ADDR  = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                acc_req,
    input  logic [AREA_W-1:0]   acc_area,
    input  logic                acc_mux,
    input  logic                bus_rdy,
    output logic                acc_busy,
    output logic                acc_done,
    output logic                cfg_err
);
    logic             gw;
    logic [CS_N-1:0]  cs_fast, rdy_en;
    logic [LEN_W-1:0] len;
    logic             rdy_use, cfg_bad;

    bwc_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .MODE_ADDR(MODE_ADDR), .CSC_ADDR(CSC_ADDR), .GRD_ADDR(GRD_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .gw(gw), .cs_fast(cs_fast), .rdy_en(rdy_en)
    );

    bwc_len u_len (
        .area(acc_area), .mux(acc_mux), .gw(gw), .cs_fast(cs_fast),
        .rdy_en(rdy_en), .len(len), .rdy_use(rdy_use), .cfg_bad(cfg_bad)
    );

    bwc_timer u_timer (
        .clk(clk), .rst_n(rst_n), .req(acc_req), .len(len),
        .rdy_use(rdy_use), .cfg_bad(cfg_bad), .rdy(bus_rdy),
        .busy(acc_busy), .done(acc_done), .err(cfg_err)
    );

    logic taken;
    assign taken = acc_req && (!acc_busy || acc_done);

    // R4
    fixed_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && acc_area[AREA_W-1:1] == '0) |=> (!acc_done ##1 acc_done));
    // R5
    gw_no_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && gw) |=> !acc_done);
    // R7
    mux_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && acc_area[AREA_W-1] && acc_mux) |=> !acc_done ##1 !acc_done);
endmodule

// File: tb/bus_wait_ctrl_tb.sv
module bus_wait_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       acc_req = 1'b0;
    logic [2:0] acc_area = '0;
    logic       acc_mux = 1'b0;
    logic       bus_rdy = 1'b1;
    logic       acc_busy, acc_done, cfg_err;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    bus_wait_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_req(acc_req),
        .acc_area(acc_area), .acc_mux(acc_mux), .bus_rdy(bus_rdy),
        .acc_busy(acc_busy), .acc_done(acc_done), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic set_gw(input logic g);
        wr(4'hA, 8'h02);
        wr(4'h5, {g, 7'b0});
        wr(4'hA, 8'h00);
    endtask

    function automatic int base_len(input logic g, input logic [3:0] fast,
                                    input logic [2:0] a, input logic m);
        if (a < 3'd2)      return 2;
        if (a < 3'd4)      return g ? 2 : 1;
        if (m)             return 3;
        if (g)             return 2;
        return fast[a[1:0]] ? 1 : 2;
    endfunction

    // Runs one access; bus_rdy is low for k clocks starting at the base length.
    task automatic run_acc(input logic [2:0] a, input logic m, input int base,
                           input int k, output int len);
        @(negedge clk);
        acc_area = a; acc_mux = m; acc_req = 1'b1; bus_rdy = 1'b1;
        @(negedge clk);
        acc_req = 1'b0;
        len = 0;
        for (int n = 1; n < 20; n++) begin
            bus_rdy = !(n >= base && n < base + k);
            #1;
            if (acc_done) begin
                len = n;
                break;
            end
            @(negedge clk);
        end
        bus_rdy = 1'b1;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int v, len, exp, a_int;
        logic err_exp;
        logic [3:0] ren;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 busy", int'(acc_busy), 0);
        chk("R1 done", int'(acc_done), 0);
        chk("R1 cfg_err", int'(cfg_err), 0);
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk("R1 rdata", v, 0);
        end

        // R3 guard closed: mode write ignored
        wr(4'h5, 8'hFF);
        rd(4'h5, v); chk("R3 closed write", v, 0);
        // R2 guard readback, mode field width
        wr(4'hA, 8'hFF);
        rd(4'hA, v); chk("R2 guard readback", v, 8'h02);
        wr(4'h5, 8'hFF);
        rd(4'h5, v); chk("R3 open write", v, 8'h80);
        wr(4'hA, 8'h00);
        wr(4'h5, 8'h00);
        rd(4'h5, v); chk("R3 closed again", v, 8'h80);
        // R2 chip-select register and unmapped address
        wr(4'h8, 8'hA5);
        rd(4'h8, v); chk("R2 cs readback", v, 8'hA5);
        rd(4'h3, v); chk("R2 unmapped", v, 0);
        set_gw(1'b0);
        rd(4'h5, v); chk("R2 mode cleared", v, 0);

        // Sweep R4..R10: ready enabled on regions 0 and 2, rdy low 1 clock at end
        ren = 4'b0101;
        err_exp = 1'b0;
        for (int g = 0; g < 2; g++) begin
            set_gw(g[0]);
            for (int f = 0; f < 16; f++) begin
                wr(4'h8, {f[3:0], ren});
                for (int a = 0; a < 8; a++) begin
                    for (int m = 0; m < 2; m++) begin
                        a_int = base_len(g[0], f[3:0], 3'(a), m[0]);
                        exp = a_int;
                        if (a >= 4 && ren[a - 4] && a_int >= 2) exp = a_int + 1;
                        run_acc(3'(a), m[0], a_int, 1, len);
                        if (a < 2)       chk("R4 fixed area", len, exp);
                        else if (a < 4)  chk("R5 internal", len, exp);
                        else if (m == 1) chk("R7 R9 mux", len, exp);
                        else             chk("R6 R10 separate", len, exp);
                        if (a >= 4 && m == 1 && f[a - 4]) err_exp = 1'b1;
                        chk("R8 cfg_err", int'(cfg_err), int'(err_exp));
                    end
                end
            end
        end

        // R9 multi-clock stretch, R10 disabled region ignores long low ready
        set_gw(1'b0);
        wr(4'h8, 8'h01);
        run_acc(3'd4, 1'b0, 2, 3, len); chk("R9 stretch 3", len, 5);
        run_acc(3'd5, 1'b0, 2, 3, len); chk("R10 ready off", len, 2);
        run_acc(3'd2, 1'b0, 1, 3, len); chk("R10 internal", len, 1);

        // R11 request during a busy cycle is ignored
        @(negedge clk);
        acc_area = 3'd4; acc_mux = 1'b1; acc_req = 1'b1;
        @(negedge clk);
        acc_area = 3'd0; acc_mux = 1'b0;
        #1 chk("R11 not done p1", int'(acc_done), 0);
        @(negedge clk);
        acc_req = 1'b0;
        #1 chk("R11 not done p2", int'(acc_done), 0);
        @(negedge clk);
        #1 chk("R11 done p3", int'(acc_done), 1);
        @(negedge clk);
        #1 chk("R11 idle after", int'(acc_busy), 0);
        chk("R11 no extra done", int'(acc_done), 0);

        // R11 back-to-back 1-clock cycles
        @(negedge clk);
        acc_area = 3'd2; acc_mux = 1'b0; acc_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1 chk("R11 back-to-back", int'(acc_done), 1);
        end
        acc_req = 1'b0;
        @(negedge clk);
        #1 chk("R11 release", int'(acc_busy), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule